// File: doc/BRIEF.md
# Register-Mapped SPI Word Master

This block is a serial peripheral interface master that software drives through eight 16-bit registers on even byte offsets. Software sets a clock-enable bit, a divisor exponent and two interrupt enables in a first configuration register. It picks the sample edge, the chip-select polarity and the interrupt style in a second. It loads a 32-bit transmit word split into low and high halves. It then writes the control register with a frame length and a read or write command, and polls the status register until the matching done flag rises. A read captures the received bits into a split 32-bit receive word. A write only transmits.

Frames are 4 to 32 bits long and are shifted most significant bit first, starting from the top bit of the transmit word, so the high half goes out first. Any length of 8 bits or fewer is sent as a 16-bit frame. Software therefore places a byte in the upper byte of the transmit high half. The serial clock idles low and is divided down from the block clock by a power of two. The chip select is active for the whole frame, and software can also hold it active between frames.

Top module: `spi_word_master`

## Requirements
- R1: After reset every register reads 0, `spi_sclk` is 0, `spi_cs` is 1 (inactive, active-low polarity) and both interrupt outputs are 0.
- R2: Register offsets: 0x0 config A, 0x2 config B, 0x4 control, 0x6 status (writes ignored), 0x8/0xA transmit low/high, 0xC/0xE receive low/high (read-only). Config A holds enable bit 0, divisor bits 3:1, write-done interrupt enable bit 4 and read-done interrupt enable bit 5. Config B holds sample edge bit 0, chip-select polarity bit 5 and interrupt style bit 10. Control reads back the size field (bits 6:2) and the hold bit 7, and reads its command bits as 0.
- R3: While a frame runs, `spi_sclk` goes through one low half then one high half per bit, each half lasting 2^divisor block clocks. It is 0 whenever no frame runs.
- R4: The control size field holds the length minus one. The frame has that many bits, except that a length of 8 or fewer gives 16 bits. The bits are taken MSB first from bit 31 of {transmit high, transmit low}, one rising `spi_sclk` edge per bit.
- R5: A read (control bit 0) stores the last frame-length received bits right-justified in {receive high, receive low}, with the upper bits 0. A write (control bit 1) leaves the receive registers unchanged.
- R6: Config B bit 0 = 1 samples `spi_miso` at each rising `spi_sclk` edge. A value of 0 samples it at each falling edge.
- R7: Status bit 0 is the read-done flag and bit 1 the write-done flag. Starting a command clears its flag, and the flag sets once that frame ends.
- R8: A control write carrying a command bit while config A bit 0 is 0, or while a frame runs, is ignored as a whole: no frame, no flag change, no size or hold change.
- R9: The chip select is active during every frame and whenever control bit 7 is set. The active level is 0 when config B bit 5 is 0 and 1 when it is 1.
- R10: An interrupt output asserts only when its enable is set. With config B bit 10 = 0 it follows its done flag. With bit 10 = 1 it pulses for one cycle when the flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 1 | Chip select, polarity set in config B |
| irq_rd_done | output | 1 | Read-done interrupt |
| irq_wr_done | output | 1 | Write-done interrupt |

## Verification
The in-line assertions check on every cycle these points: the serial clock stays low outside a frame and freezes while the enable is clear, a frame only starts with the enable set, a done flag only rises from a finished frame of its own kind, the chip select is at its active level throughout a frame, and an edge-style interrupt never lasts two cycles. Only the bench scenarios can show the data itself. A loopback slave checks received words across every length and several divisors. A slave that launches on rising edges separates the two sample-edge settings. The scenarios also cover the half-period length, the clearing of flags, the ignored commands and the readback of the register fields.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;

  localparam logic [3:0] OFS_CFG_A = 4'h0;
  localparam logic [3:0] OFS_CFG_B = 4'h2;
  localparam logic [3:0] OFS_CTRL  = 4'h4;
  localparam logic [3:0] OFS_STAT  = 4'h6;
  localparam logic [3:0] OFS_TXL   = 4'h8;
  localparam logic [3:0] OFS_TXH   = 4'hA;
  localparam logic [3:0] OFS_RXL   = 4'hC;
  localparam logic [3:0] OFS_RXH   = 4'hE;

  localparam int SHORT_MAX  = 8;
  localparam int SHORT_BITS = 16;

  // number of bits shifted for a given size field (length minus one)
  function automatic int frame_bits(input int size_field);
    int n;
    n = size_field + 1;
    return (n <= SHORT_MAX) ? SHORT_BITS : n;
  endfunction

  // block clocks per serial clock half period
  function automatic int half_period(input int div_exp);
    return 1 << div_exp;
  endfunction

endpackage

// File: rtl/spi_wm_baud.sv
module spi_wm_baud #(
  parameter int DIV_W = 3,
  parameter int CNT_W = 2 ** DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_exp,
  output logic             half_tick
);
  import spi_wm_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last      = CNT_W'(half_period(int'(div_exp)) - 1);
  assign half_tick = run && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (half_tick) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  // R3: the counter never passes the half-period limit
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run && $stable(div_exp) |-> cnt <= last);

endmodule

// File: rtl/spi_wm_shift.sv
module spi_wm_shift #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              sample_rise,
  input  logic              half_tick,
  input  logic              miso,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] shreg;
  logic [LEN_W-1:0]  left;
  logic              rise_evt;
  logic              fall_evt;

  assign rise_evt = busy && half_tick && !sclk;
  assign fall_evt = busy && half_tick && sclk;
  assign mosi     = shreg[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      done    <= 1'b0;
      shreg   <= '0;
      rx_word <= '0;
      left    <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        sclk    <= 1'b0;
        shreg   <= tx_word;
        rx_word <= '0;
        left    <= frame_len;
      end else if (rise_evt) begin
        sclk <= 1'b1;
        if (sample_rise) rx_word <= {rx_word[DATA_W-2:0], miso};
      end else if (fall_evt) begin
        sclk  <= 1'b0;
        if (!sample_rise) rx_word <= {rx_word[DATA_W-2:0], miso};
        shreg <= {shreg[DATA_W-2:0], 1'b0};
        left  <= left - 1'b1;
        if (left == LEN_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R3: serial clock idles low outside a frame
  a_r3_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  // R4: remaining count stays within the frame range while busy
  a_r4_left_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (left != '0) && (left <= LEN_W'(DATA_W)));
  // R4: completion follows a falling serial clock edge of a running frame
  a_r4_done_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy) && $past(sclk));

endmodule

// File: rtl/spi_wm_irq.sv
module spi_wm_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic flag,
  input  logic enable,
  input  logic edge_mode,
  output logic irq
);
  logic flag_q;
  logic flag_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag;
  end

  assign flag_set = flag && !flag_q;
  assign irq      = enable && (edge_mode ? flag_set : flag);

  // R10: pulse style never holds the line two cycles
  a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode && irq |=> !edge_mode || !irq);

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master #(
  parameter int REG_W = 16,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [3:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             spi_cs,
  output logic             irq_rd_done,
  output logic             irq_wr_done
);
  import spi_wm_pkg::*;

  localparam int DATA_W  = 2 * REG_W;
  localparam int SZ_W    = $clog2(DATA_W);
  localparam int LEN_W   = $clog2(DATA_W + 1);
  localparam int IEW_BIT = DIV_W + 1;
  localparam int IER_BIT = DIV_W + 2;
  localparam int CSH_BIT = SZ_W + 2;
  localparam int POL_BIT = 5;
  localparam int TRG_BIT = 10;

  logic             clk_en, ie_wr, ie_rd;
  logic [DIV_W-1:0] div_exp;
  logic             edge_rise, cs_pol, trig_edge;
  logic [SZ_W-1:0]  size_f;
  logic             cs_hold;
  logic [REG_W-1:0] tx_lo, tx_hi, rx_lo, rx_hi;
  logic             flag_rd, flag_wr, op_rd, op_wr;

  logic             ctrl_wr, cmd_bits, cmd_go;
  logic             xfer_busy, xfer_done, half_tick;
  logic [DATA_W-1:0] rx_word;
  logic [LEN_W-1:0] start_len;
  logic             cs_act;

  assign ctrl_wr   = reg_we && (reg_addr == OFS_CTRL);
  assign cmd_bits  = reg_wdata[0] || reg_wdata[1];
  assign cmd_go    = ctrl_wr && cmd_bits && clk_en && !xfer_busy;
  assign start_len = LEN_W'(frame_bits(int'(reg_wdata[SZ_W+1:2])));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en <= 1'b0; div_exp <= '0; ie_wr <= 1'b0; ie_rd <= 1'b0;
      edge_rise <= 1'b0; cs_pol <= 1'b0; trig_edge <= 1'b0;
      size_f <= '0; cs_hold <= 1'b0; tx_lo <= '0; tx_hi <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        OFS_CFG_A: begin
          clk_en  <= reg_wdata[0];
          div_exp <= reg_wdata[DIV_W:1];
          ie_wr   <= reg_wdata[IEW_BIT];
          ie_rd   <= reg_wdata[IER_BIT];
        end
        OFS_CFG_B: begin
          edge_rise <= reg_wdata[0];
          cs_pol    <= reg_wdata[POL_BIT];
          trig_edge <= reg_wdata[TRG_BIT];
        end
        OFS_CTRL: if (!cmd_bits || cmd_go) begin
          size_f  <= reg_wdata[SZ_W+1:2];
          cs_hold <= reg_wdata[CSH_BIT];
        end
        OFS_TXL: tx_lo <= reg_wdata;
        OFS_TXH: tx_hi <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_rd <= 1'b0; flag_wr <= 1'b0; op_rd <= 1'b0; op_wr <= 1'b0;
      rx_lo <= '0; rx_hi <= '0;
    end else begin
      if (xfer_done) begin
        if (op_rd) begin
          flag_rd <= 1'b1;
          rx_lo   <= rx_word[REG_W-1:0];
          rx_hi   <= rx_word[DATA_W-1:REG_W];
        end
        if (op_wr) flag_wr <= 1'b1;
      end
      if (cmd_go) begin
        op_rd <= reg_wdata[0];
        op_wr <= reg_wdata[1];
        if (reg_wdata[0]) flag_rd <= 1'b0;
        if (reg_wdata[1]) flag_wr <= 1'b0;
      end
    end
  end

  spi_wm_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(xfer_busy && clk_en),
    .div_exp(div_exp), .half_tick(half_tick)
  );

  spi_wm_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(cmd_go), .frame_len(start_len),
    .tx_word({tx_hi, tx_lo}), .sample_rise(edge_rise), .half_tick(half_tick),
    .miso(spi_miso), .busy(xfer_busy), .sclk(spi_sclk), .mosi(spi_mosi),
    .done(xfer_done), .rx_word(rx_word)
  );

  logic [1:0] flag_v, ie_v, irq_v;
  assign flag_v = {flag_wr, flag_rd};
  assign ie_v   = {ie_wr, ie_rd};

  for (genvar gi = 0; gi < 2; gi++) begin : g_irq
    spi_wm_irq u_irq (
      .clk(clk), .rst_n(rst_n), .flag(flag_v[gi]), .enable(ie_v[gi]),
      .edge_mode(trig_edge), .irq(irq_v[gi])
    );
  end

  assign irq_rd_done = irq_v[0];
  assign irq_wr_done = irq_v[1];

  assign cs_act = xfer_busy || cs_hold;
  assign spi_cs = cs_pol ? cs_act : !cs_act;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CFG_A: begin
        reg_rdata[0]       = clk_en;
        reg_rdata[DIV_W:1] = div_exp;
        reg_rdata[IEW_BIT] = ie_wr;
        reg_rdata[IER_BIT] = ie_rd;
      end
      OFS_CFG_B: begin
        reg_rdata[0]       = edge_rise;
        reg_rdata[POL_BIT] = cs_pol;
        reg_rdata[TRG_BIT] = trig_edge;
      end
      OFS_CTRL: begin
        reg_rdata[SZ_W+1:2] = size_f;
        reg_rdata[CSH_BIT]  = cs_hold;
      end
      OFS_STAT: begin
        reg_rdata[0] = flag_rd;
        reg_rdata[1] = flag_wr;
      end
      OFS_TXL: reg_rdata = tx_lo;
      OFS_TXH: reg_rdata = tx_hi;
      OFS_RXL: reg_rdata = rx_lo;
      OFS_RXH: reg_rdata = rx_hi;
      default: reg_rdata = '0;
    endcase
  end

  // R8: a frame only begins while the serial clock enable is set
  a_r8_start_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_busy) |-> $past(clk_en));
  // R8: serial clock frozen while the enable is clear
  a_r8_sclk_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(spi_sclk));
  // R7: a done flag rises only from a finished frame of its own kind
  a_r7_rd_flag_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_rd) |-> $past(xfer_done && op_rd));
  a_r7_wr_flag_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_wr) |-> $past(xfer_done && op_wr));
  // R9: chip select at its active level for the whole frame
  a_r9_cs_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |-> spi_cs == cs_pol);

endmodule

// File: tb/spi_word_master_bench.sv
module spi_word_master_bench;
  localparam logic [3:0] A_CFGA = 4'h0, A_CFGB = 4'h2, A_CTRL = 4'h4,
                         A_STAT = 4'h6, A_TXL = 4'h8, A_TXH = 4'hA,
                         A_RXL = 4'hC, A_RXH = 4'hE;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic spi_sclk, spi_mosi, spi_miso, spi_cs, irq_rd_done, irq_wr_done;

  int checks = 0, errors = 0;
  int rise_cnt = 0, hi_cnt = 0, irq_cnt = 0, cs_bad = 0;
  int slv_idx = 0;
  logic slv_mode = 1'b0;
  logic exp_cs_act = 1'b0;
  logic [63:0] slv_pat = 64'hC3A5_96F0_1E2D_7B48;

  always #4 clk = ~clk;

  spi_word_master u_spi_word_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs),
    .irq_rd_done(irq_rd_done), .irq_wr_done(irq_wr_done)
  );

  assign spi_miso = slv_mode ? slv_pat[63 - slv_idx] : spi_mosi;

  always @(posedge spi_sclk) begin
    rise_cnt++;
    slv_idx++;
  end
  always @(negedge clk) begin
    if (spi_sclk) hi_cnt++;
    if (irq_wr_done) irq_cnt++;
    if (spi_sclk && spi_cs != exp_cs_act) cs_bad++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [15:0] cfga(input int div, input bit en, input bit iew, input bit ier);
    return 16'(en) | 16'(div << 1) | (16'(iew) << 4) | (16'(ier) << 5);
  endfunction
  function automatic logic [15:0] ctrlw(input bit r, input bit w, input int n, input bit hold);
    return 16'(r) | (16'(w) << 1) | 16'((n - 1) << 2) | (16'(hold) << 7);
  endfunction
  function automatic int fbits(input int n);
    return (n <= 8) ? 16 : n;
  endfunction
  function automatic logic [63:0] nmask(input int fb);
    return (64'd1 << fb) - 64'd1;
  endfunction

  // issue a command and poll its done flag; returns 1 on timeout
  task automatic frame(input bit r, input bit w, input int n, output bit tmo);
    logic [15:0] s;
    rise_cnt = 0; hi_cnt = 0; slv_idx = 0;
    wr(A_CTRL, ctrlw(r, w, n, 1'b0));
    tmo = 1'b1;
    for (int k = 0; k < 20000; k++) begin
      rd(A_STAT, s);
      if ((r && s[0]) || (!r && s[1])) begin tmo = 1'b0; break; end
    end
  endtask

  task automatic load_tx(input logic [31:0] t);
    wr(A_TXL, t[15:0]);
    wr(A_TXH, t[31:16]);
  endtask

  task automatic read_rx(output logic [31:0] v);
    logic [15:0] lo, hi;
    rd(A_RXL, lo); rd(A_RXH, hi);
    v = {hi, lo};
  endtask

  initial begin
    logic [15:0] d;
    logic [31:0] rxv, tx, rx_prev;
    bit tmo;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 16; a += 2) begin
      rd(4'(a), d);
      chk($sformatf("R1 reset reg %0h", a), 64'(d), 64'd0);
    end
    chk("R1 reset sclk", 64'(spi_sclk), 64'd0);
    chk("R1 reset cs", 64'(spi_cs), 64'd1);
    chk("R1 reset irqs", 64'({irq_rd_done, irq_wr_done}), 64'd0);

    // R2 readback
    wr(A_CFGA, 16'hFFFF); rd(A_CFGA, d); chk("R2 cfgA fields", 64'(d), 64'h3F);
    wr(A_CFGB, 16'hFFFF); rd(A_CFGB, d); chk("R2 cfgB fields", 64'(d), 64'h0421);
    wr(A_CFGB, 16'h0000);
    wr(A_CFGA, 16'h0000);
    wr(A_CTRL, 16'hFFFC); rd(A_CTRL, d); chk("R2 ctrl fields", 64'(d), 64'hFC);
    wr(A_CTRL, 16'h0000);
    wr(A_STAT, 16'hFFFF); rd(A_STAT, d); chk("R2 status write ignored", 64'(d), 64'd0);
    wr(A_RXL, 16'h1234); rd(A_RXL, d); chk("R2 rx read-only", 64'(d), 64'd0);
    load_tx(32'hBEEF_0A55);
    rd(A_TXL, d); chk("R2 tx low", 64'(d), 64'h0A55);
    rd(A_TXH, d); chk("R2 tx high", 64'(d), 64'hBEEF);

    // R3 R4 R5: loopback sweep of every length and three divisors
    for (int dv = 0; dv < 3; dv++) begin
      wr(A_CFGA, cfga(dv, 1'b1, 1'b0, 1'b0));
      for (int n = 4; n <= 32; n++) begin
        tx = 32'hA5C3_0F96 ^ (32'(n) * 32'h0101_0101) ^ (32'(dv) << 20);
        load_tx(tx);
        frame(1'b1, 1'b0, n, tmo);
        chk($sformatf("R7 read done n=%0d", n), 64'(tmo), 64'd0);
        read_rx(rxv);
        chk($sformatf("R5 loopback n=%0d div=%0d", n, dv), 64'(rxv),
            ({32'd0, tx} >> (32 - fbits(n))) & nmask(fbits(n)));
        chk($sformatf("R4 edges n=%0d", n), 64'(rise_cnt), 64'(fbits(n)));
        chk($sformatf("R3 high cycles n=%0d div=%0d", n, dv), 64'(hi_cnt),
            64'(fbits(n) * (1 << dv)));
      end
    end
    chk("R9 cs active in every frame", 64'(cs_bad), 64'd0);
    chk("R3 sclk idle low", 64'(spi_sclk), 64'd0);

    // R6: slave launching on rising edges separates the sample edges
    slv_mode = 1'b1;
    wr(A_CFGA, cfga(1, 1'b1, 1'b0, 1'b0));
    foreach (slv_pat[i]) if (i < 0) break;
    for (int e = 0; e < 2; e++) begin
      wr(A_CFGB, 16'(e));
      for (int w = 0; w < 4; w++) begin
        int n, fb;
        n = (w == 0) ? 4 : (w == 1) ? 8 : (w == 2) ? 16 : 32;
        fb = fbits(n);
        frame(1'b1, 1'b0, n, tmo);
        read_rx(rxv);
        if (e == 1)
          chk($sformatf("R6 rising sample n=%0d", n), 64'(rxv), (slv_pat >> (64 - fb)) & nmask(fb));
        else
          chk($sformatf("R6 falling sample n=%0d", n), 64'(rxv), (slv_pat >> (63 - fb)) & nmask(fb));
      end
    end
    slv_mode = 1'b0;
    wr(A_CFGB, 16'h0000);

    // R5 R7: write leaves rx alone, sets only write flag
    read_rx(rx_prev);
    load_tx(32'h1357_9BDF);
    frame(1'b0, 1'b1, 16, tmo);
    chk("R7 write done", 64'(tmo), 64'd0);
    read_rx(rxv);
    chk("R5 write keeps rx", 64'(rxv), 64'(rx_prev));
    rd(A_STAT, d); chk("R7 both flags", 64'(d), 64'h3);
    wr(A_CTRL, ctrlw(1'b0, 1'b1, 32, 1'b0));
    rd(A_STAT, d); chk("R7 write cmd clears write flag", 64'(d), 64'h1);
    repeat (200) @(negedge clk);
    rd(A_STAT, d); chk("R7 write flag after frame", 64'(d), 64'h3);

    // R8: command during a frame is ignored
    rise_cnt = 0;
    wr(A_CTRL, ctrlw(1'b1, 1'b0, 16, 1'b0));
    wr(A_CTRL, ctrlw(1'b0, 1'b1, 32, 1'b1));
    repeat (300) @(negedge clk);
    chk("R8 busy command ignored edges", 64'(rise_cnt), 64'd16);
    rd(A_STAT, d); chk("R8 busy command keeps write flag", 64'(d), 64'h3);
    rd(A_CTRL, d); chk("R8 busy command keeps size", 64'(d), 64'(15 << 2));

    // R8: command with enable clear is ignored
    wr(A_CFGA, cfga(1, 1'b0, 1'b0, 1'b0));
    rise_cnt = 0;
    wr(A_CTRL, ctrlw(1'b1, 1'b1, 8, 1'b1));
    repeat (100) @(negedge clk);
    chk("R8 disabled no sclk", 64'(rise_cnt), 64'd0);
    rd(A_STAT, d); chk("R8 disabled flags kept", 64'(d), 64'h3);
    chk("R8 disabled cs idle", 64'(spi_cs), 64'd1);

    // R9: hold bit and polarity
    wr(A_CTRL, ctrlw(1'b0, 1'b0, 16, 1'b1));
    chk("R9 hold asserts cs low", 64'(spi_cs), 64'd0);
    wr(A_CFGB, 16'h0020);
    chk("R9 hold with high polarity", 64'(spi_cs), 64'd1);
    wr(A_CTRL, ctrlw(1'b0, 1'b0, 16, 1'b0));
    chk("R9 released high polarity", 64'(spi_cs), 64'd0);
    exp_cs_act = 1'b1; cs_bad = 0;
    wr(A_CFGA, cfga(0, 1'b1, 1'b0, 1'b0));
    frame(1'b1, 1'b0, 12, tmo);
    chk("R9 high polarity during frame", 64'(cs_bad), 64'd0);
    wr(A_CFGB, 16'h0000);
    exp_cs_act = 1'b0;

    // R10: level and pulse interrupts
    wr(A_CFGA, cfga(0, 1'b1, 1'b0, 1'b0));
    frame(1'b0, 1'b1, 16, tmo);
    chk("R10 no irq without enable", 64'(irq_wr_done), 64'd0);
    wr(A_CFGA, cfga(0, 1'b1, 1'b1, 1'b0));
    frame(1'b0, 1'b1, 16, tmo);
    repeat (4) @(negedge clk);
    chk("R10 level irq held", 64'(irq_wr_done), 64'd1);
    chk("R10 read irq quiet", 64'(irq_rd_done), 64'd0);
    wr(A_CFGB, 16'h0400);
    irq_cnt = 0;
    frame(1'b0, 1'b1, 16, tmo);
    repeat (4) @(negedge clk);
    chk("R10 pulse irq one cycle", 64'(irq_cnt), 64'd1);
    chk("R10 pulse irq released", 64'(irq_wr_done), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule